// File: doc/BRIEF.md
# Windowed Stack Pointer Sequencer

This block holds the stack pointer of a small 8-bit processor core whose stack lives in a fixed 64-byte page at the top of the first 256 bytes of memory. Only six pointer bits are stored. Every stack address is made by putting those six bits under a constant upper pattern. Going past 64 entries wraps silently inside the page.

The core asks for single-byte pushes and pulls. It also asks for four multi-byte frames: subroutine call, subroutine return, interrupt entry and return from interrupt. For each stack access the block drives the memory address, a read or write strobe, and a tag naming the register byte being moved. While a frame is in progress it raises busy. Strobes and the address are combinational from the current state and request inputs. The pointer and frame state are registered.

Top module: `stk_ptr_engine`

## Requirements
- R1: After reset the pointer is at 0x00FF, `busy` is 0 and both strobes are 0. When no strobe is active, `stk_addr` shows the pointer's current location.
- R2: `sp_reset` loads the pointer with 0x00FF at the next edge, produces no strobe in its own cycle, takes precedence over every other request and cancels any frame in progress.
- R3: Every stack address has the upper ten bits 0000000011, so it lies in 0x00C0..0x00FF.
- R4: A single push drives `wr_en` in the same cycle, with the address equal to the pointer, and then decrements the pointer. A decrement from 0x00C0 gives 0x00FF.
- R5: A single pull increments the pointer and drives `rd_en` in the same cycle, with the address equal to the incremented pointer. An increment from 0x00FF gives 0x00C0.
- R6: When push and pull are requested together while idle, the push is performed and the pull is dropped. The two strobes are never both high.
- R7: A call request produces two write cycles, beginning the cycle after the request. The tags are 0 (PC low) and then 1 (PC high), at descending addresses.
- R8: A subroutine return produces two read cycles, beginning the cycle after the request, with tags 1 (PC high) and then 0 (PC low).
- R9: Interrupt entry produces five write cycles, beginning the cycle after the request, with tags 0, 1, 2 (X), 3 (A), 4 (CCR).
- R10: Return from interrupt produces five read cycles, beginning the cycle after the request, with tags 4, 3, 2, 1, 0.
- R11: `busy` is high in exactly the byte cycles of a frame. Any frame, push or pull request made while busy is ignored, and the running frame continues unchanged.
- R12: When idle, simultaneous frame requests are served in the order interrupt entry, call, return from interrupt, subroutine return. Any frame request beats a single push or pull in the same cycle.
- R13: A single push or pull carries tag 5. The tag is also 5 in every cycle without a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_reset | input | 1 | Reload pointer to top of page |
| push_req | input | 1 | Single-byte push |
| pull_req | input | 1 | Single-byte pull |
| call_req | input | 1 | Start call frame (2 writes) |
| ret_req | input | 1 | Start return frame (2 reads) |
| irq_req | input | 1 | Start interrupt frame (5 writes) |
| rti_req | input | 1 | Start interrupt-return frame (5 reads) |
| stk_addr | output | 16 | Stack memory address |
| rd_en | output | 1 | Stack read strobe |
| wr_en | output | 1 | Stack write strobe |
| byte_tag | output | 3 | Register byte being moved |
| busy | output | 1 | Frame in progress |

## Verification
Two sets of actions can fall in the same cycle. A pointer reload can coincide with a frame byte or a single push. A push and a pull can be requested together while idle. The bench raises `sp_reset` in the middle of an interrupt frame and together with a push. It also drives push and pull in one cycle. A behavioural model judges each case on every clock: in that cycle the reload must win with no strobe, and the frame must be dropped; the push must win with the pull lost. The model's pointer and address are then compared in the cycles that follow.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        BK_CALL = 2'd0,
        BK_RET  = 2'd1,
        BK_IRQ  = 2'd2,
        BK_RTI  = 2'd3
    } burst_kind_e;

    typedef enum logic [2:0] {
        TG_PCL  = 3'd0,
        TG_PCH  = 3'd1,
        TG_XR   = 3'd2,
        TG_ACC  = 3'd3,
        TG_CCR  = 3'd4,
        TG_DATA = 3'd5
    } byte_tag_e;

    localparam int IDX_W = 3;

    typedef struct packed {
        logic              active;
        burst_kind_e       kind;
        logic [IDX_W-1:0]  idx;
    } seq_state_t;

    function automatic logic [IDX_W-1:0] burst_len(burst_kind_e k);
        case (k)
            BK_CALL, BK_RET: return IDX_W'(2);
            default:         return IDX_W'(5);
        endcase
    endfunction

    function automatic logic burst_is_push(burst_kind_e k);
        return (k == BK_CALL) || (k == BK_IRQ);
    endfunction

    function automatic byte_tag_e burst_tag(burst_kind_e k, logic [IDX_W-1:0] i);
        byte_tag_e t;
        t = TG_DATA;
        case (k)
            BK_CALL: t = (i == 0) ? TG_PCL : TG_PCH;
            BK_RET:  t = (i == 0) ? TG_PCH : TG_PCL;
            BK_IRQ: begin
                case (i)
                    3'd0:    t = TG_PCL;
                    3'd1:    t = TG_PCH;
                    3'd2:    t = TG_XR;
                    3'd3:    t = TG_ACC;
                    default: t = TG_CCR;
                endcase
            end
            default: begin
                case (i)
                    3'd0:    t = TG_CCR;
                    3'd1:    t = TG_ACC;
                    3'd2:    t = TG_XR;
                    3'd3:    t = TG_PCH;
                    default: t = TG_PCL;
                endcase
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/stk_window_addr.sv
module stk_window_addr #(
    parameter int              ADDR_W   = 16,
    parameter int              PTR_W    = 6,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h00C0
) (
    input  logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - PTR_W;
    localparam logic [HI_W-1:0] HI_PAT = WIN_BASE[ADDR_W-1:PTR_W];

    always_comb begin
        addr = {HI_PAT, ptr};
    end
endmodule

// File: rtl/stk_ptr_step.sv
module stk_ptr_step #(
    parameter int PTR_W = 6
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic             inc,
    input  logic             dec,
    output logic [PTR_W-1:0] ahead,
    output logic [PTR_W-1:0] nxt
);
    always_comb begin
        ahead = ptr + PTR_W'(1);
        if (dec)
            nxt = ptr - PTR_W'(1);
        else if (inc)
            nxt = ahead;
        else
            nxt = ptr;
    end
endmodule

// File: rtl/stk_burst_seq.sv
module stk_burst_seq
    import stk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        abort,
    input  logic        start_vld,
    input  burst_kind_e start_kind,
    output logic        active,
    output logic        is_push,
    output byte_tag_e   tag,
    output logic        last
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (abort) begin
            st_d.active = 1'b0;
            st_d.idx    = '0;
        end else if (st_q.active) begin
            if (last) begin
                st_d.active = 1'b0;
                st_d.idx    = '0;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end else if (start_vld) begin
            st_d.active = 1'b1;
            st_d.kind   = start_kind;
            st_d.idx    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{active: 1'b0, kind: BK_CALL, idx: '0};
        else
            st_q <= st_d;
    end

    always_comb begin
        active  = st_q.active;
        is_push = burst_is_push(st_q.kind);
        tag     = burst_tag(st_q.kind, st_q.idx);
        last    = st_q.active && (st_q.idx == burst_len(st_q.kind) - IDX_W'(1));
    end

    p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && start_vld && !abort) |=> (st_q.active && st_q.idx == '0 && st_q.kind == $past(start_kind)));

    p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !abort && !last) |=> (st_q.active && st_q.idx == $past(st_q.idx) + IDX_W'(1) && st_q.kind == $past(st_q.kind)));

    p_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !abort) |=> !st_q.active);

    p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !st_q.active);
endmodule

// File: rtl/stk_ptr_engine.sv
module stk_ptr_engine
    import stk_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                PTR_W    = 6,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h00C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sp_reset,
    input  logic              push_req,
    input  logic              pull_req,
    input  logic              call_req,
    input  logic              ret_req,
    input  logic              irq_req,
    input  logic              rti_req,
    output logic [ADDR_W-1:0] stk_addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic [2:0]        byte_tag,
    output logic              busy
);
    localparam logic [PTR_W-1:0] PTR_TOP = '1;

    typedef struct packed {
        logic [PTR_W-1:0] sp;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    logic             seq_active, seq_push, seq_last;
    byte_tag_e        seq_tag;
    logic             start_vld;
    burst_kind_e      start_kind;
    logic             take, any_frame, single_wr, single_rd, burst_go;
    logic [PTR_W-1:0] sp_ahead, sp_next, addr_ptr;

    always_comb begin
        take       = !seq_active && !sp_reset;
        any_frame  = irq_req || call_req || rti_req || ret_req;
        start_vld  = take && any_frame;
        if (irq_req)       start_kind = BK_IRQ;
        else if (call_req) start_kind = BK_CALL;
        else if (rti_req)  start_kind = BK_RTI;
        else               start_kind = BK_RET;
        single_wr  = take && !any_frame && push_req;
        single_rd  = take && !any_frame && !push_req && pull_req;
        burst_go   = seq_active && !sp_reset;
        wr_en      = single_wr || (burst_go && seq_push);
        rd_en      = single_rd || (burst_go && !seq_push);
        byte_tag   = burst_go ? 3'(seq_tag) : 3'(TG_DATA);
        busy       = seq_active;
        addr_ptr   = rd_en ? sp_ahead : st_q.sp;
    end

    stk_burst_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (sp_reset),
        .start_vld  (start_vld),
        .start_kind (start_kind),
        .active     (seq_active),
        .is_push    (seq_push),
        .tag        (seq_tag),
        .last       (seq_last)
    );

    stk_ptr_step #(.PTR_W(PTR_W)) u_step (
        .ptr   (st_q.sp),
        .inc   (rd_en),
        .dec   (wr_en),
        .ahead (sp_ahead),
        .nxt   (sp_next)
    );

    stk_window_addr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .WIN_BASE(WIN_BASE)) u_addr (
        .ptr  (addr_ptr),
        .addr (stk_addr)
    );

    always_comb begin
        st_d = st_q;
        if (sp_reset)
            st_d.sp = PTR_TOP;
        else
            st_d.sp = sp_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{sp: PTR_TOP};
        else
            st_q <= st_d;
    end

    p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> (stk_addr[ADDR_W-1:PTR_W] == WIN_BASE[ADDR_W-1:PTR_W]));

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sp_reset |=> (st_q.sp == PTR_TOP && !busy));

    p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.sp == $past(st_q.sp) - PTR_W'(1)));

    p_pull_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (st_q.sp == $past(st_q.sp) + PTR_W'(1)));

    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    p_single_tag_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !busy) |-> (byte_tag == 3'(TG_DATA)));

    p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_last && !sp_reset) |=> !busy);
endmodule

// File: tb/stk_ptr_engine_test.sv
`timescale 1ns/1ps
module stk_ptr_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sp_reset = 0, push_req = 0, pull_req = 0;
    logic        call_req = 0, ret_req = 0, irq_req = 0, rti_req = 0;
    logic [15:0] stk_addr;
    logic        rd_en, wr_en, busy;
    logic [2:0]  byte_tag;

    int n_tests = 0;
    int n_fail  = 0;
    int msp     = 63;
    bit mbusy   = 0;
    int fq[$];
    bit done    = 0;

    always #5 clk = ~clk;

    stk_ptr_engine uut (
        .clk(clk), .rst_n(rst_n), .sp_reset(sp_reset),
        .push_req(push_req), .pull_req(pull_req),
        .call_req(call_req), .ret_req(ret_req),
        .irq_req(irq_req), .rti_req(rti_req),
        .stk_addr(stk_addr), .rd_en(rd_en), .wr_en(wr_en),
        .byte_tag(byte_tag), .busy(busy)
    );

    task automatic chk(input string lbl, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", lbl, what, act, exp);
        end
    endtask

    task automatic load(input int kind_push, input int tags[$]);
        foreach (tags[k]) fq.push_back(kind_push * 8 + tags[k]);
        mbusy = 1;
    endtask

    // one clock: drive at negedge, compare 1 ns later, advance model
    task automatic cyc(input string lbl, input bit p, input bit pl, input bit c,
                       input bit r, input bit i, input bit ti, input bit rs);
        int ea, ew, er, et, eb, e;
        push_req = p; pull_req = pl; call_req = c; ret_req = r;
        irq_req = i; rti_req = ti; sp_reset = rs;
        #1;
        ew = 0; er = 0; et = 5; eb = mbusy; ea = 192 + msp;
        if (rs) begin
            fq.delete(); mbusy = 0; msp = 63;
        end else if (mbusy) begin
            e = fq.pop_front();
            if (e >= 8) begin ew = 1; msp = (msp + 63) % 64; end
            else begin msp = (msp + 1) % 64; er = 1; ea = 192 + msp; end
            et = e % 8;
            if (fq.size() == 0) mbusy = 0;
        end else if (i)  load(1, '{0, 1, 2, 3, 4});
        else if (c)      load(1, '{0, 1});
        else if (ti)     load(0, '{4, 3, 2, 1, 0});
        else if (r)      load(0, '{1, 0});
        else if (p) begin ew = 1; msp = (msp + 63) % 64; end
        else if (pl) begin msp = (msp + 1) % 64; er = 1; ea = 192 + msp; end
        chk(lbl, "addr", stk_addr, ea);
        chk(lbl, "wr_en", wr_en, ew);
        chk(lbl, "rd_en", rd_en, er);
        chk(lbl, "tag", byte_tag, et);
        chk(lbl, "busy", busy, eb);
        @(negedge clk);
    endtask

    task automatic idle(input string lbl, input int n);
        for (int k = 0; k < n; k++) cyc(lbl, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "addr", stk_addr, 16'h00FF);
        chk("R1", "busy", busy, 0);
        chk("R1", "strobes", {rd_en, wr_en}, 0);
        @(negedge clk);
        idle("R1", 1);
        // single pushes and pulls, tag 5 (R13)
        for (int k = 0; k < 3; k++) cyc("R4", 1, 0, 0, 0, 0, 0, 0);
        for (int k = 0; k < 2; k++) cyc("R5", 0, 1, 0, 0, 0, 0, 0);
        idle("R13", 1);
        // push and pull together: push wins
        cyc("R6", 1, 1, 0, 0, 0, 0, 0);
        cyc("R6", 1, 1, 0, 0, 0, 0, 0);
        idle("R6", 1);
        // wrap both ways across the page edge (R3)
        for (int k = 0; k < 66; k++) cyc("R4", 1, 0, 0, 0, 0, 0, 0);
        idle("R3", 1);
        for (int k = 0; k < 70; k++) cyc("R5", 0, 1, 0, 0, 0, 0, 0);
        idle("R3", 1);
        // frames
        cyc("R7", 0, 0, 1, 0, 0, 0, 0); idle("R7", 3);
        cyc("R8", 0, 0, 0, 1, 0, 0, 0); idle("R8", 3);
        cyc("R9", 0, 0, 0, 0, 1, 0, 0); idle("R9", 6);
        cyc("R10", 0, 0, 0, 0, 0, 1, 0); idle("R10", 6);
        // requests while busy are ignored
        cyc("R11", 0, 0, 1, 0, 0, 0, 0);
        cyc("R11", 1, 0, 0, 0, 1, 0, 0);
        cyc("R11", 0, 1, 0, 1, 0, 1, 0);
        idle("R11", 2);
        cyc("R11", 0, 0, 0, 0, 1, 0, 0);
        for (int k = 0; k < 5; k++) cyc("R11", 1, 1, 1, 1, 1, 1, 0);
        idle("R11", 2);
        // priority among simultaneous frame requests
        cyc("R12", 1, 0, 1, 0, 1, 0, 0); idle("R12", 6);
        cyc("R12", 0, 1, 1, 1, 0, 1, 0); idle("R12", 3);
        cyc("R12", 0, 0, 0, 1, 0, 1, 0); idle("R12", 6);
        cyc("R12", 1, 1, 0, 1, 0, 0, 0); idle("R12", 3);
        // reload against a frame and a push
        cyc("R2", 0, 0, 0, 0, 1, 0, 0);
        idle("R2", 2);
        cyc("R2", 1, 0, 0, 0, 0, 0, 1);
        idle("R2", 2);
        for (int k = 0; k < 4; k++) cyc("R2", 1, 0, 0, 0, 0, 0, 0);
        cyc("R2", 1, 0, 0, 0, 0, 0, 1);
        cyc("R2", 0, 1, 0, 0, 0, 0, 0);
        cyc("R2", 0, 0, 1, 0, 0, 0, 1);
        idle("R2", 3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule